// File: doc/BRIEF.md
# Timer Input Capture Channel

This block is one channel of a free-running timer. A counter of `CNT_W` bits advances once per enabled prescaler tick while the start input is high. A general register holds a copy of the count taken at the moment a capture event occurs. It then raises a capture flag, which software clears with a strobe.

A capture event has one of three sources. The first is an edge on an external pin: rising, falling or either. The second is the counter clock enable of a neighbouring channel. The third is the compare-match pulse of that neighbour. When the neighbour's counter runs on the undivided system clock, its clock enable cannot act as a trigger, and no capture is taken from it.

Setup order: first put the general register into capture mode and choose the source and edge. Then raise the start input so counting begins. In compare mode the register is a plain software-writable value and never captures.

Top module: `tcap_channel`

## Requirements
- R1: While `rst` is high, `cnt`, `gr` and `cap_flag` all read 0.
- R2: With `start` = 1 and `presc_tick` = 1, `cnt` grows by one per clock and wraps from its all-ones value to 0.
- R3: When `start` = 0 or `presc_tick` = 0, `cnt` keeps its value.
- R4: With source code 0 (pin), the pin goes through a two-stage synchronizer. Edge code 0 fires on rising changes, code 1 on falling changes, and codes 2 and 3 on any change. A matching pin change applied just after a clock edge loads `gr` on the third following edge, with the count that was visible two clocks after the change.
- R5: With source code 1 (neighbour clock), a clock edge at which `nb_clk_en` is high loads `gr` with the count visible before that edge.
- R6: With source code 1, nothing is captured while `nb_clk_div1` is high, whatever `nb_clk_en` does.
- R7: With source code 2 (neighbour compare match), a clock edge at which `nb_cmp_match` is high loads `gr`. `nb_clk_en` has no effect under this code. Code 3 disables capture.
- R8: A capture on the same edge as a counter increment stores the value from before the increment.
- R9: `cap_flag` rises on the edge that loads `gr` by capture and stays high until `flag_clr` is seen. If a clear and a capture coincide, the flag ends high.
- R10: With `cfg_capture` = 1, `gr_wr_en` has no effect on `gr`. With `cfg_capture` = 0, `gr_wr_en` loads `gr_wr_data` on the next edge, and no source event changes `gr` or `cap_flag`.
- R11: Configuration inputs act one clock after they are applied. A change of source or edge selection blinds the pin detector for the first cycle under the new setting, so a pin change that arrives with the switch causes no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Count enable (start bit) |
| presc_tick | input | 1 | Prescaler tick for this channel's counter |
| cfg_capture | input | 1 | 1: general register captures, 0: compare mode |
| cfg_src | input | 2 | Capture source: 0 pin, 1 neighbour clock, 2 neighbour compare match, 3 none |
| cfg_edge | input | 2 | Pin edge: 0 rising, 1 falling, 2/3 both |
| pin_in | input | 1 | Asynchronous capture pin |
| nb_clk_en | input | 1 | Neighbour channel counter clock enable |
| nb_clk_div1 | input | 1 | Neighbour counter runs on the undivided clock |
| nb_cmp_match | input | 1 | Neighbour compare-match pulse |
| gr_wr_en | input | 1 | Software write strobe for the general register |
| gr_wr_data | input | CNT_W | Software write data |
| flag_clr | input | 1 | Software clear strobe for the capture flag |
| cnt | output | CNT_W | Counter value |
| gr | output | CNT_W | General register (captured value) |
| cap_flag | output | 1 | Capture flag |

## Verification
The bench builds the channel with `CNT_W` = 8. This lets a few hundred cycles cover every wrap of the counter, and the bench checks each step of the count. It sweeps every edge code against both pin transition directions and works out the expected register value from the count plus the synchronizer latency. It then runs each neighbour source, the undivided-clock block, the collision between clear and set, write masking in both modes, and the one-cycle blind window after a configuration switch.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

    typedef enum logic [1:0] {
        SRC_PIN   = 2'd0,
        SRC_NBCLK = 2'd1,
        SRC_NBCMP = 2'd2,
        SRC_OFF   = 2'd3
    } cap_src_e;

    typedef enum logic [1:0] {
        EDG_RISE = 2'd0,
        EDG_FALL = 2'd1,
        EDG_BOTH = 2'd2,
        EDG_ANY  = 2'd3
    } edge_sel_e;

    typedef struct packed {
        logic      capture_mode;
        cap_src_e  src;
        edge_sel_e edge_sel;
    } tcap_cfg_t;

    // Edge qualifier: current synchronized sample against the previous one.
    function automatic logic edge_hit(edge_sel_e sel, logic cur, logic prv);
        logic r;
        case (sel)
            EDG_RISE: r = cur & ~prv;
            EDG_FALL: r = ~cur & prv;
            default:  r = cur ^ prv;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tcap_pin_edge.sv
module tcap_pin_edge
    import tcap_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pin,
    input  logic      rearm,
    input  edge_sel_e edge_sel,
    output logic      hit
);
    logic [STAGES-1:0] sh;
    logic              prev;
    logic              prev_ok;
    logic              smp;

    assign smp = sh[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sh      <= '0;
            prev    <= 1'b0;
            prev_ok <= 1'b0;
        end else begin
            sh      <= {sh[STAGES-2:0], pin};
            prev    <= smp;
            prev_ok <= ~rearm;
        end
    end

    assign hit = prev_ok & edge_hit(edge_sel, smp, prev);

endmodule

// File: rtl/tcap_counter.sv
module tcap_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (run && tick)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/tcap_gen_reg.sv
module tcap_gen_reg #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_fire,
    input  logic [CNT_W-1:0] cnt,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] gr,
    output logic             flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            gr   <= '0;
            flag <= 1'b0;
        end else begin
            if (cap_fire)
                gr <= cnt;
            else if (wr_en)
                gr <= wr_data;

            if (cap_fire)
                flag <= 1'b1;
            else if (flag_clr)
                flag <= 1'b0;
        end
    end
endmodule

// File: rtl/tcap_channel.sv
module tcap_channel
    import tcap_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             presc_tick,
    input  logic             cfg_capture,
    input  logic [1:0]       cfg_src,
    input  logic [1:0]       cfg_edge,
    input  logic             pin_in,
    input  logic             nb_clk_en,
    input  logic             nb_clk_div1,
    input  logic             nb_cmp_match,
    input  logic             gr_wr_en,
    input  logic [CNT_W-1:0] gr_wr_data,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] gr,
    output logic             cap_flag
);
    tcap_cfg_t cfg_d, cfg_q;
    logic      cfg_sel_chg;
    logic      pin_hit;
    logic      src_evt;
    logic      cap_fire;

    assign cfg_d.capture_mode = cfg_capture;
    assign cfg_d.src          = cap_src_e'(cfg_src);
    assign cfg_d.edge_sel     = edge_sel_e'(cfg_edge);

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '{capture_mode: 1'b0, src: SRC_OFF, edge_sel: EDG_RISE};
        else
            cfg_q <= cfg_d;
    end

    // A pending change of source or edge re-arms the pin detector.
    assign cfg_sel_chg = (cfg_d.src != cfg_q.src) || (cfg_d.edge_sel != cfg_q.edge_sel);

    tcap_pin_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .pin      (pin_in),
        .rearm    (cfg_sel_chg),
        .edge_sel (cfg_q.edge_sel),
        .hit      (pin_hit)
    );

    always_comb begin
        case (cfg_q.src)
            SRC_PIN:   src_evt = pin_hit;
            SRC_NBCLK: src_evt = nb_clk_en & ~nb_clk_div1;
            SRC_NBCMP: src_evt = nb_cmp_match;
            default:   src_evt = 1'b0;
        endcase
    end

    assign cap_fire = cfg_q.capture_mode & src_evt;

    tcap_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .run  (start),
        .tick (presc_tick),
        .cnt  (cnt)
    );

    tcap_gen_reg #(.CNT_W(CNT_W)) u_gr (
        .clk      (clk),
        .rst      (rst),
        .cap_fire (cap_fire),
        .cnt      (cnt),
        .wr_en    (gr_wr_en & ~cfg_q.capture_mode),
        .wr_data  (gr_wr_data),
        .flag_clr (flag_clr),
        .gr       (gr),
        .flag     (cap_flag)
    );

endmodule

// File: rtl/tcap_channel_chk.sv
module tcap_channel_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             presc_tick,
    input logic             nb_clk_div1,
    input logic             gr_wr_en,
    input logic             flag_clr,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] gr,
    input logic             cap_flag,
    input logic             cap_fire,
    input logic             capture_mode_q,
    input logic [1:0]       src_q
);
    a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
        (start && presc_tick) |=> cnt == CNT_W'($past(cnt) + 1'b1));

    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        !(start && presc_tick) |=> cnt == $past(cnt));

    a_r8_pre_increment: assert property (@(posedge clk) disable iff (rst)
        cap_fire |=> gr == $past(cnt));

    a_r9_flag_set: assert property (@(posedge clk) disable iff (rst)
        cap_fire |=> cap_flag);

    a_r9_flag_clear: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !cap_fire) |=> !cap_flag);

    a_r10_write_masked: assert property (@(posedge clk) disable iff (rst)
        (capture_mode_q && gr_wr_en && !cap_fire) |=> $stable(gr));

    a_r6_div1_blocks: assert property (@(posedge clk) disable iff (rst)
        (src_q == 2'd1 && nb_clk_div1 && !(gr_wr_en && !capture_mode_q)) |=> $stable(gr));

    a_r1_reset: assert property (@(posedge clk)
        rst |=> (cnt == '0 && gr == '0 && !cap_flag));
endmodule

bind tcap_channel tcap_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .start          (start),
    .presc_tick     (presc_tick),
    .nb_clk_div1    (nb_clk_div1),
    .gr_wr_en       (gr_wr_en),
    .flag_clr       (flag_clr),
    .cnt            (cnt),
    .gr             (gr),
    .cap_flag       (cap_flag),
    .cap_fire       (cap_fire),
    .capture_mode_q (cfg_q.capture_mode),
    .src_q          (cfg_q.src)
);

// File: tb/tb_tcap_channel.sv
module tb_tcap_channel;
    localparam int W    = 8;
    localparam int MASK = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0, presc_tick = 1'b0, cfg_capture = 1'b0;
    logic [1:0]   cfg_src = 2'd3, cfg_edge = 2'd0;
    logic         pin_in = 1'b0, nb_clk_en = 1'b0, nb_clk_div1 = 1'b0, nb_cmp_match = 1'b0;
    logic         gr_wr_en = 1'b0, flag_clr = 1'b0;
    logic [W-1:0] gr_wr_data = '0;
    logic [W-1:0] cnt, gr;
    logic         cap_flag;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    tcap_channel #(.CNT_W(W)) dut (
        .clk(clk), .rst(rst), .start(start), .presc_tick(presc_tick),
        .cfg_capture(cfg_capture), .cfg_src(cfg_src), .cfg_edge(cfg_edge),
        .pin_in(pin_in), .nb_clk_en(nb_clk_en), .nb_clk_div1(nb_clk_div1),
        .nb_cmp_match(nb_cmp_match), .gr_wr_en(gr_wr_en), .gr_wr_data(gr_wr_data),
        .flag_clr(flag_clr), .cnt(cnt), .gr(gr), .cap_flag(cap_flag)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        step(1);
        flag_clr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired (all requirements) actual=hang expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int c0, g0, wv;
        bit exp_hit;

        // R1: reset state while inputs are active
        start = 1'b1; presc_tick = 1'b1; nb_cmp_match = 1'b1; cfg_capture = 1'b1; cfg_src = 2'd2;
        step(3);
        chk("R1 cnt", cnt, 0);
        chk("R1 gr", gr, 0);
        chk("R1 cap_flag", cap_flag, 0);
        nb_cmp_match = 1'b0; cfg_src = 2'd3;
        rst = 1'b0;
        step(2);

        // R2: step and wrap, over more than one full period
        for (int i = 0; i < 300; i++) begin
            c0 = cnt;
            step(1);
            chk("R2 count step", cnt, (c0 + 1) & MASK);
        end

        // R3: hold with no tick, then with start low
        presc_tick = 1'b0;
        c0 = cnt; step(3);
        chk("R3 hold no tick", cnt, c0);
        presc_tick = 1'b1; start = 1'b0;
        step(1); c0 = cnt; step(3);
        chk("R3 hold start low", cnt, c0);
        start = 1'b1;

        // R4: every edge code against both transition directions
        for (int e = 0; e < 4; e++) begin
            for (int d = 0; d < 2; d++) begin
                cfg_src = 2'd3;
                pin_in = (d == 1);
                step(4);
                cfg_src = 2'd0; cfg_edge = 2'(e);
                step(4);
                clear_flag();
                g0 = gr;
                pin_in = ~pin_in;
                c0 = cnt;
                step(3);
                exp_hit = (e >= 2) || (e == 0 && d == 0) || (e == 1 && d == 1);
                chk($sformatf("R4 flag edge=%0d dir=%0d", e, d), cap_flag, int'(exp_hit));
                chk($sformatf("R4 gr edge=%0d dir=%0d", e, d), gr,
                    exp_hit ? ((c0 + 2) & MASK) : g0);
            end
        end

        // R5 / R8: neighbour clock enable as source
        cfg_src = 2'd1; nb_clk_div1 = 1'b0;
        step(3);
        clear_flag();
        c0 = cnt;
        nb_clk_en = 1'b1;
        step(1);
        nb_clk_en = 1'b0;
        chk("R5 gr", gr, c0);
        chk("R5 flag", cap_flag, 1);
        chk("R8 counter moved on capture edge", cnt, (c0 + 1) & MASK);

        // R6: undivided neighbour clock blocks capture
        clear_flag();
        step(2);
        g0 = gr;
        nb_clk_div1 = 1'b1; nb_clk_en = 1'b1;
        step(3);
        nb_clk_en = 1'b0; nb_clk_div1 = 1'b0;
        chk("R6 flag", cap_flag, 0);
        chk("R6 gr", gr, g0);

        // R7: compare-match source; clock enable ignored under it
        cfg_src = 2'd2;
        step(2);
        clear_flag();
        c0 = cnt;
        nb_cmp_match = 1'b1;
        step(1);
        nb_cmp_match = 1'b0;
        chk("R7 gr", gr, c0);
        chk("R7 flag", cap_flag, 1);
        clear_flag();
        g0 = gr;
        nb_clk_en = 1'b1;
        step(1);
        nb_clk_en = 1'b0;
        chk("R7 clk enable ignored flag", cap_flag, 0);
        chk("R7 clk enable ignored gr", gr, g0);

        // R9: set beats clear, then clear alone
        nb_cmp_match = 1'b1; flag_clr = 1'b1;
        step(1);
        nb_cmp_match = 1'b0; flag_clr = 1'b0;
        chk("R9 set wins", cap_flag, 1);
        step(2);
        chk("R9 flag sticky", cap_flag, 1);
        clear_flag();
        chk("R9 cleared", cap_flag, 0);

        // R10: write masked in capture mode, accepted in compare mode
        g0 = gr;
        wv = (~g0) & MASK;
        gr_wr_data = W'(wv); gr_wr_en = 1'b1;
        step(1);
        gr_wr_en = 1'b0;
        chk("R10 write ignored", gr, g0);
        cfg_capture = 1'b0;
        step(1);
        gr_wr_data = 8'h3C; gr_wr_en = 1'b1;
        step(1);
        gr_wr_en = 1'b0;
        chk("R10 compare write", gr, 8'h3C);
        nb_cmp_match = 1'b1;
        step(1);
        nb_cmp_match = 1'b0;
        chk("R10 no capture flag", cap_flag, 0);
        chk("R10 no capture gr", gr, 8'h3C);

        // R11: configuration acts one clock later
        cfg_capture = 1'b1; cfg_src = 2'd3;
        step(3);
        clear_flag();
        cfg_src = 2'd1; nb_clk_en = 1'b1;
        step(1);
        nb_clk_en = 1'b0;
        chk("R11 config delayed", cap_flag, 0);

        // R11: pin change arriving with a source switch is ignored
        cfg_src = 2'd3; cfg_edge = 2'd0; pin_in = 1'b0;
        step(4);
        clear_flag();
        g0 = gr;
        pin_in = 1'b1;
        step(1);
        cfg_src = 2'd0;
        step(5);
        chk("R11 blind flag", cap_flag, 0);
        chk("R11 blind gr", gr, g0);

        // R4: detector is live again afterwards
        pin_in = 1'b0;
        step(4);
        pin_in = 1'b1;
        c0 = cnt;
        step(3);
        chk("R4 live after rearm", gr, (c0 + 2) & MASK);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule